// File: doc/BRIEF.md
# CPU Performance-Level Controller with Safe Fast-Entry Sequencing

The block keeps four CPU performance levels (level 0 is the fastest, level 3 the slowest). A per-level source-select code and a divider code are packed in two configuration words. One of the four levels is active at a time, and the block drives that level's source and divider onto its outputs. When dynamic mode is off, the outputs come from a single static selection word instead.

A requester asks for a new rate by presenting a divider code. The block scans levels 0 to 3 and takes the first level whose divider matches. A direct jump into level 0 from a slow level can starve the core supply when the base clock is fast. In that case the block first parks on level 1. It holds there for a programmable number of millisecond ticks and only then enters level 0. An earlier, fully elapsed stay on level 1 lets level 0 be entered at once. While the block parks on level 1, `busy` is high and further requests are ignored.

Top module: `dvfs_level_ctrl`

## Requirements
- R1: After reset the active level is 0, `busy` and `req_err` are low, every register is zero, and `src_sel`/`div_sel` read 0.
- R2: With dynamic mode on (bit 31 of word 0x24), the outputs follow the active level. Level 0 uses the upper half of word 0x18 and level 1 uses its lower half. Level 2 uses the upper half of word 0x1C and level 3 uses its lower half. Inside a half, the divider is bits 15:13 and the source is bits 10:9.
- R3: With dynamic mode off, `src_sel` is bits 1:0 and `div_sel` is bits 4:2 of the static word at 0x04, whatever level is active.
- R4: A request selects the lowest-numbered level whose divider equals `req_div`. When no level matches, or dynamic mode is off, `req_err` is high for one cycle after the request and the level does not change.
- R5: A request that resolves to level 2 or 3, or to level 0 while `base_fast` is low, changes the level at the next clock edge and leaves `busy` low.
- R6: With `base_fast` high, a level-0 request taken without an elapsed level-1 stay moves the block to level 1 with `busy` high. The block enters level 0 with `busy` low on the edge that samples the DWELL_MS-th `ms_tick`.
- R7: Entering level 1 from level 0 counts as an elapsed stay, so a following level-0 request enters level 0 directly.
- R8: Entering level 1 from level 2 or 3 starts a stay of DWELL_MS ticks. A level-0 request enters level 0 directly only once those ticks have passed. Before that, the request triggers the full stay of R6.
- R9: A request for the already active level clears any elapsed or pending stay.
- R10: While `busy` is high, requests have no effect on the level.
- R11: A write to word 0x30 sets the level from data bits 1:0 and clears any stay, but only while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register byte offset |
| wr_data | input | 32 | Register write data |
| req_valid | input | 1 | Rate request strobe |
| req_div | input | 3 | Requested divider code |
| base_fast | input | 1 | High when the parent clock is at or above the 1 GHz threshold |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| level | output | 2 | Active performance level |
| src_sel | output | 2 | Active source-select code |
| div_sel | output | 3 | Active divider code |
| busy | output | 1 | Parked on level 1, waiting to enter level 0 |
| req_err | output | 1 | Previous request found no usable level |

## Verification
The hardest state to reach is level 1 entered from a slow level, with its stay still running or just elapsed. This state decides whether a level-0 request parks or goes straight through. It is reached only through a chain of requests: first a slow level, then level 1, then a chosen number of ticks. The bench builds that chain with a short stay length and tries level 0 both before and after the stay runs out. It also repeats the chain after a level-1 entry from level 0 and after a same-level request, which cancels the stay.

// File: rtl/dvfs_pkg.sv
// Shared types and register offsets for the performance-level controller.
package dvfs_pkg;
    localparam int NLVL   = 4;
    localparam int LVL_W  = 2;
    localparam int DIV_W  = 3;
    localparam int SRC_W  = 2;
    localparam int HALF_W = 16;
    localparam int DIV_LSB = 13;
    localparam int SRC_LSB = 9;

    localparam logic [7:0] A_STATIC = 8'h04;
    localparam logic [7:0] A_CFG01  = 8'h18;
    localparam logic [7:0] A_CFG23  = 8'h1C;
    localparam logic [7:0] A_MODE   = 8'h24;
    localparam logic [7:0] A_LOAD   = 8'h30;

    typedef logic [LVL_W-1:0] lvl_t;
    typedef logic [DIV_W-1:0] dcode_t;
    typedef logic [SRC_W-1:0] scode_t;

    typedef enum logic [1:0] { EXP_NONE = 2'd0, EXP_ARMED = 2'd1, EXP_DONE = 2'd2 } exp_e;
    typedef enum logic       { SQ_IDLE = 1'b0, SQ_DWELL = 1'b1 } seq_e;
endpackage

// File: rtl/dvfs_field_decode.sv
// Splits the two packed configuration words into per-level divider and
// source codes. Assumes even levels sit in the upper half-word, odd in the lower.
module dvfs_field_decode
    import dvfs_pkg::*;
(
    input  logic [31:0]                 cfg01,
    input  logic [31:0]                 cfg23,
    output logic [NLVL-1:0][DIV_W-1:0]  lvl_div,
    output logic [NLVL-1:0][SRC_W-1:0]  lvl_src
);
    for (genvar g = 0; g < NLVL; g++) begin : g_lvl
        localparam int OFF = ((g % 2) == 0) ? HALF_W : 0;
        logic [31:0] word;
        // pick the word that carries this level
        always_comb word = (g < 2) ? cfg01 : cfg23;
        assign lvl_div[g] = word[OFF+DIV_LSB +: DIV_W];
        assign lvl_src[g] = word[OFF+SRC_LSB +: SRC_W];
    end
endmodule

// File: rtl/dvfs_level_match.sv
// Priority search over the levels: the lowest level whose divider equals
// the requested code wins. Assumes divider codes are already decoded.
module dvfs_level_match
    import dvfs_pkg::*;
(
    input  logic [NLVL-1:0][DIV_W-1:0] lvl_div,
    input  dcode_t                     want,
    output logic                       hit,
    output lvl_t                       idx
);
    logic [NLVL-1:0] eq;

    for (genvar g = 0; g < NLVL; g++) begin : g_eq
        assign eq[g] = (lvl_div[g] == want);
    end

    // scan from the slowest level down so the lowest match is kept
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = NLVL - 1; i >= 0; i--) begin
            if (eq[i]) begin
                hit = 1'b1;
                idx = lvl_t'(i);
            end
        end
    end
endmodule

// File: rtl/dvfs_seq.sv
// Level register and fast-entry sequencer. Tracks the level-1 stay state
// and parks on level 1 before level 0 when the base clock is fast.
// Assumes req_go and wr_go are never asserted while busy.
module dvfs_seq
    import dvfs_pkg::*;
#(
    parameter int DWELL_MS = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_go,
    input  lvl_t tgt,
    input  logic base_fast,
    input  logic ms_tick,
    input  logic wr_go,
    input  lvl_t wr_lvl,
    output lvl_t level,
    output logic busy
);
    localparam int CNT_W = $clog2(DWELL_MS + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DWELL_MS);

    seq_e             st;
    exp_e             exp_st;
    logic [CNT_W-1:0] cnt;

    assign busy = (st == SQ_DWELL);

    // level, stay state and tick counter update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level  <= '0;
            st     <= SQ_IDLE;
            exp_st <= EXP_NONE;
            cnt    <= '0;
        end else if (st == SQ_DWELL) begin
            if (ms_tick) begin
                if (cnt <= 1) begin
                    level  <= '0;
                    st     <= SQ_IDLE;
                    exp_st <= EXP_NONE;
                    cnt    <= '0;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end else begin
            if (exp_st == EXP_ARMED && ms_tick) begin
                if (cnt <= 1) begin
                    exp_st <= EXP_DONE;
                    cnt    <= '0;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
            if (wr_go) begin
                level  <= wr_lvl;
                exp_st <= EXP_NONE;
                cnt    <= '0;
            end else if (req_go) begin
                if (tgt == level) begin
                    exp_st <= EXP_NONE;
                    cnt    <= '0;
                end else if (tgt == lvl_t'(1)) begin
                    level <= lvl_t'(1);
                    if (level == lvl_t'(0)) begin
                        exp_st <= EXP_DONE;
                        cnt    <= '0;
                    end else begin
                        exp_st <= EXP_ARMED;
                        cnt    <= CNT_FULL;
                    end
                end else if (tgt == lvl_t'(0)) begin
                    if (!base_fast || exp_st == EXP_DONE) begin
                        level  <= '0;
                        exp_st <= EXP_NONE;
                        cnt    <= '0;
                    end else begin
                        level  <= lvl_t'(1);
                        st     <= SQ_DWELL;
                        exp_st <= EXP_NONE;
                        cnt    <= CNT_FULL;
                    end
                end else begin
                    level  <= tgt;
                    exp_st <= EXP_NONE;
                    cnt    <= '0;
                end
            end
        end
    end

    a_r6_park_on_one: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> level == lvl_t'(1));
    a_r10_hold_level: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy) |-> $stable(level));
    a_r6_exit_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> level == lvl_t'(0));
    a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_FULL);
    a_r7_done_on_one: assert property (@(posedge clk) disable iff (!rst_n)
        (exp_st != EXP_NONE) |-> level == lvl_t'(1));
endmodule

// File: rtl/dvfs_level_ctrl.sv
// Top: register file, output selection and request qualification around
// the field decoder, level matcher and sequencer. Assumes ms_tick is a
// one-cycle pulse in the clk domain.
module dvfs_level_ctrl
    import dvfs_pkg::*;
#(
    parameter int DWELL_MS = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [7:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic        req_valid,
    input  logic [2:0]  req_div,
    input  logic        base_fast,
    input  logic        ms_tick,
    output logic [1:0]  level,
    output logic [1:0]  src_sel,
    output logic [2:0]  div_sel,
    output logic        busy,
    output logic        req_err
);
    logic [31:0]                cfg01, cfg23;
    logic                       dyn_on;
    logic [DIV_W+SRC_W-1:0]     stat_q;
    logic [NLVL-1:0][DIV_W-1:0] lvl_div;
    logic [NLVL-1:0][SRC_W-1:0] lvl_src;
    logic                       hit;
    lvl_t                       hit_idx;
    logic                       wr_go, req_eval, req_go;

    // configuration and mode registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg01  <= '0;
            cfg23  <= '0;
            dyn_on <= 1'b0;
            stat_q <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_CFG01:  cfg01  <= wr_data;
                A_CFG23:  cfg23  <= wr_data;
                A_MODE:   dyn_on <= wr_data[31];
                A_STATIC: stat_q <= wr_data[DIV_W+SRC_W-1:0];
                default:  ;
            endcase
        end
    end

    dvfs_field_decode u_dec (
        .cfg01   (cfg01),
        .cfg23   (cfg23),
        .lvl_div (lvl_div),
        .lvl_src (lvl_src)
    );

    dvfs_level_match u_match (
        .lvl_div (lvl_div),
        .want    (req_div),
        .hit     (hit),
        .idx     (hit_idx)
    );

    assign wr_go    = wr_en && (wr_addr == A_LOAD) && !busy;
    assign req_eval = req_valid && !busy && !wr_go;
    assign req_go   = req_eval && dyn_on && hit;

    dvfs_seq #(.DWELL_MS(DWELL_MS)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_go    (req_go),
        .tgt       (hit_idx),
        .base_fast (base_fast),
        .ms_tick   (ms_tick),
        .wr_go     (wr_go),
        .wr_lvl    (wr_data[LVL_W-1:0]),
        .level     (level),
        .busy      (busy)
    );

    // one-cycle error flag for unusable requests
    always_ff @(posedge clk) begin
        if (!rst_n) req_err <= 1'b0;
        else        req_err <= req_eval && (!dyn_on || !hit);
    end

    // drive the active source and divider
    always_comb begin
        if (dyn_on) begin
            src_sel = lvl_src[level];
            div_sel = lvl_div[level];
        end else begin
            src_sel = stat_q[SRC_W-1:0];
            div_sel = stat_q[SRC_W +: DIV_W];
        end
    end

    a_r4_err_keeps_level: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> level == $past(level));
    a_r4_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (req_err && !$past(req_valid && !busy)) |-> 1'b0);
    a_r10_busy_no_err: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy) |-> !req_err);
endmodule

// File: tb/dvfs_level_ctrl_tb.sv
module dvfs_level_ctrl_tb;
    localparam int DW = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_div = '0;
    logic        base_fast = 1'b0;
    logic        ms_tick = 1'b0;
    logic [1:0]  level, src_sel;
    logic [2:0]  div_sel;
    logic        busy, req_err;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dvfs_level_ctrl #(.DWELL_MS(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .req_valid(req_valid), .req_div(req_div),
        .base_fast(base_fast), .ms_tick(ms_tick), .level(level),
        .src_sel(src_sel), .div_sel(div_sel), .busy(busy), .req_err(req_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic req(input logic [2:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_div = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ms_tick = 1'b1;
            @(negedge clk);
            ms_tick = 1'b0;
        end
    endtask

    // level/busy pair check
    task automatic st(input string tag, input int l, input int b);
        chk({tag, " level"}, level, l);
        chk({tag, " busy"}, busy, b);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        st("R1", 0, 0);
        chk("R1 err", req_err, 0);
        chk("R1 src", src_sel, 0);
        chk("R1 div", div_sel, 0);

        // R3 static selection sweep over every code, across levels
        for (int v = 0; v < 32; v++) begin
            wr(8'h04, 32'(v));
            wr(8'h30, 32'(v % 4));
            chk("R3 src", src_sel, v % 4);
            chk("R3 div", div_sel, v / 4);
        end

        // R2 field positions swept for every level, divider and source
        wr(8'h24, 32'h8000_0000);
        for (int l = 0; l < 4; l++) begin
            for (int v = 0; v < 32; v++) begin
                int half;
                int word;
                half = ((v / 4) << 13) | ((v % 4) << 9);
                word = (l % 2 == 0) ? (half << 16) : half;
                wr((l < 2) ? 8'h18 : 8'h1C, 32'(word));
                wr(8'h30, 32'(l));
                chk("R2 src", src_sel, v % 4);
                chk("R2 div", div_sel, v / 4);
            end
        end

        // R4 lowest matching level wins: L1 and L2 both hold divider 2
        wr(8'h18, (32'd1 << 29) | (32'd2 << 13));
        wr(8'h1C, (32'd2 << 29) | (32'd6 << 13));
        wr(8'h30, 32'd3);
        req(3'd2);
        st("R4 lowest", 1, 0);
        chk("R4 no err", req_err, 0);
        req(3'd7);
        chk("R4 nomatch err", req_err, 1);
        chk("R4 nomatch level", level, 1);
        @(negedge clk);
        chk("R4 err one cycle", req_err, 0);

        // working set: divs L0=1 L1=2 L2=4 L3=6
        wr(8'h1C, (32'd4 << 29) | (32'd6 << 13));
        base_fast = 1'b0;
        req(3'd4);
        st("R5 to L2", 2, 0);
        req(3'd1);
        st("R5 slow base to L0", 0, 0);
        req(3'd6);
        st("R5 to L3", 3, 0);

        // R6 park on L1, R10 and R11 ignored while busy
        base_fast = 1'b1;
        req(3'd1);
        st("R6 park", 1, 1);
        tick(DW - 1);
        st("R6 still parked", 1, 1);
        req(3'd6);
        st("R10 req ignored", 1, 1);
        wr(8'h30, 32'd3);
        st("R11 write ignored", 1, 1);
        tick(1);
        st("R6 enter L0", 0, 0);

        // R7 L1 from L0 then direct L0
        req(3'd2);
        st("R7 to L1", 1, 0);
        req(3'd1);
        st("R7 direct L0", 0, 0);

        // R9 same-level request cancels the elapsed stay
        req(3'd2);
        req(3'd2);
        st("R9 same", 1, 0);
        req(3'd1);
        st("R9 parks", 1, 1);
        tick(DW);
        st("R9 exit", 0, 0);

        // R8 stay from L2 not yet elapsed
        req(3'd4);
        req(3'd2);
        tick(DW - 2);
        req(3'd1);
        st("R8 early parks", 1, 1);
        tick(DW);
        st("R8 early exit", 0, 0);
        // R8 stay elapsed
        req(3'd6);
        req(3'd2);
        tick(DW);
        req(3'd1);
        st("R8 elapsed direct", 0, 0);

        // R11 write while idle sets level and clears stay
        req(3'd2);
        wr(8'h30, 32'd1);
        st("R11 write", 1, 0);
        req(3'd1);
        st("R11 cleared stay", 1, 1);
        tick(DW);
        wr(8'h30, 32'd2);
        st("R11 write L2", 2, 0);

        // R4 dynamic off makes requests fail
        wr(8'h24, 32'd0);
        req(3'd1);
        chk("R4 dyn off err", req_err, 1);
        chk("R4 dyn off level", level, 2);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule